// File: doc/BRIEF.md
# Register-to-Register Execution Unit

This block carries out the two-byte register-to-register instructions of a 24-bit accumulator-style processor. On a start strobe it takes an opcode byte and a register byte, selects up to two registers on its two register-file read ports, computes the result, and presents one register write and/or a condition-code update on its write port in that same cycle. The register file commits them on the clock edge that ends the start cycle.

One cycle after each start the block raises a done pulse. An illegal-operation flag is raised together with that done pulse when the opcode is not one of the supported operations, when a register field that the operation uses holds an undefined code, or when a divide has a zero divisor. An illegal operation writes nothing.

Top module: `rrx_unit`

## Requirements
- R1: The opcode is `op_byte[7:2]`, and `op_byte[1:0]` are ignored. The first register field r1 is `reg_byte[7:4]` and the second field r2 is `reg_byte[3:0]`. The supported opcodes, given as full bytes with the low two bits zero, are: add 0x90, subtract 0x94, multiply 0x98, divide 0x9C, compare 0xA0, shift left 0xA4, shift right 0xA8, move 0xAC, clear 0xB4 and index-compare 0xB8. Any other opcode raises `illegal` and produces neither a write nor a condition-code update.
- R2: The legal register codes are 0 to 6, 8 and 9. Code 1 is the index register X. If a used field holds any other code, the operation is illegal and writes nothing. A field that the operation does not use is ignored: r2 of clear and of index-compare. In the shifts, r2 is a count and not a register code.
- R3: Add writes r2+r1 into r2 and subtract writes r2−r1 into r2, both truncated to 24 bits.
- R4: Multiply writes the low 24 bits of r2×r1 into r2. Divide writes the signed quotient r2÷r1, rounded toward zero, into r2.
- R5: A divide by zero writes nothing, updates no condition code and raises `illegal` for one cycle.
- R6: Move writes r1 into r2. Clear writes zero into r1.
- R7: With n = r2+1, shift left rotates r1 left by n bits within 24 bits, and shift right shifts r1 right logically by n bits. Both write the result back into r1.
- R8: Compare writes no register. It sets `cc_val` from a signed 24-bit comparison of r1 against r2: 0 when r1 is less, 1 when they are equal, 2 when r1 is greater.
- R9: Index-compare writes X+1 into register code 1. It sets `cc_val` by comparing that new X against r1, with the same 0/1/2 encoding.
- R10: `wr_en` and `cc_we` are only ever high during a start cycle. `done` is high exactly in the cycle after each start, and `illegal` is only ever high together with `done`.
- R11: While reset is low, and in the first cycle after it, `done` and `illegal` are low, whatever the state of `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Execute the instruction presented this cycle |
| op_byte | input | 8 | First instruction byte (opcode) |
| reg_byte | input | 8 | Second instruction byte (r1, r2 fields) |
| rd_addr_a | output | 4 | Read port A register code (r1) |
| rd_data_a | input | 24 | Read port A data |
| rd_addr_b | output | 4 | Read port B register code (r2, or X for index-compare) |
| rd_data_b | input | 24 | Read port B data |
| wr_en | output | 1 | Register write strobe, valid in the start cycle |
| wr_addr | output | 4 | Register code to write |
| wr_data | output | 24 | Value to write |
| cc_we | output | 1 | Condition-code update strobe |
| cc_val | output | 2 | New condition code (0 less, 1 equal, 2 greater) |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Illegal-operation flag, aligned with done |

## Verification
The assertions check the timing contract on every cycle. Writes and condition-code strobes appear only under start. Done follows every start and appears after no other cycle. The illegal flag rides on done. When a write and a condition-code update happen together, the write goes to X and the code is never 3. The arithmetic itself, the signed compare and divide edge cases, the rotate wrap and the legality rules for each field can only be shown by the bench's vectors, which compare each result against values worked out from the requirements.

// File: rtl/rrx_pkg.sv
// Shared types for the register-to-register execution unit.
// Assumes 4-bit register codes and opcodes taken from the top six bits of the opcode byte.
package rrx_pkg;

    localparam int CODE_W = 4;

    // Opcode values as seen in op_byte[7:2]
    typedef enum logic [5:0] {
        OPC_ADD = 6'h24,
        OPC_SUB = 6'h25,
        OPC_MUL = 6'h26,
        OPC_DIV = 6'h27,
        OPC_CMP = 6'h28,
        OPC_SHL = 6'h29,
        OPC_SHR = 6'h2A,
        OPC_MOV = 6'h2B,
        OPC_CLR = 6'h2D,
        OPC_TIX = 6'h2E
    } opc_e;

    localparam logic [CODE_W-1:0] RC_X = 4'd1;

    localparam logic [1:0] CC_LT = 2'd0;
    localparam logic [1:0] CC_EQ = 2'd1;
    localparam logic [1:0] CC_GT = 2'd2;

    // True for the defined register codes 0..6, 8 and 9
    function automatic logic reg_code_ok(input logic [CODE_W-1:0] c);
        return (c <= 4'd6) || (c == 4'd8) || (c == 4'd9);
    endfunction

endpackage

// File: rtl/rrx_decode.sv
// Instruction decoder: splits the two bytes into operation, register fields,
// read/write register codes and a legality flag. Purely combinational.
// Assumes the caller qualifies every output with its own start strobe.
module rrx_decode
    import rrx_pkg::*;
(
    input  logic [7:0]        op_byte,
    input  logic [7:0]        reg_byte,
    output opc_e              opc,
    output logic [CODE_W-1:0] r2_field,
    output logic [CODE_W-1:0] rd_addr_a,
    output logic [CODE_W-1:0] rd_addr_b,
    output logic [CODE_W-1:0] wr_addr,
    output logic              has_write,
    output logic              has_cc,
    output logic              legal
);

    logic [CODE_W-1:0] r1_field;
    logic              op_ok;
    logic              uses_r2;

    assign r1_field = reg_byte[7:4];
    assign r2_field = reg_byte[3:0];
    assign opc      = opc_e'(op_byte[7:2]);

    // Classify the opcode: is it known, which fields it reads, and what it updates
    always_comb begin
        op_ok     = 1'b1;
        uses_r2   = 1'b0;
        has_write = 1'b1;
        has_cc    = 1'b0;
        wr_addr   = r2_field;
        case (opc)
            OPC_ADD, OPC_SUB, OPC_MUL, OPC_DIV, OPC_MOV: uses_r2 = 1'b1;
            OPC_CMP: begin
                uses_r2   = 1'b1;
                has_write = 1'b0;
                has_cc    = 1'b1;
            end
            OPC_SHL, OPC_SHR, OPC_CLR: wr_addr = r1_field;
            OPC_TIX: begin
                wr_addr = RC_X;
                has_cc  = 1'b1;
            end
            default: begin
                op_ok     = 1'b0;
                has_write = 1'b0;
            end
        endcase
    end

    // Legal only when the opcode is known and every field it uses names a defined register
    assign legal = op_ok && reg_code_ok(r1_field) && (!uses_r2 || reg_code_ok(r2_field));

    assign rd_addr_a = r1_field;
    assign rd_addr_b = (opc == OPC_TIX) ? RC_X : r2_field;

endmodule

// File: rtl/rrx_alu.sv
// Datapath for the register-to-register operations. a is the r1 value,
// b is the r2 value (or X for the index-compare). Combinational.
// Assumes DATA_W is larger than the longest shift, 2**CNT_W.
module rrx_alu
    import rrx_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int CNT_W  = 4
) (
    input  opc_e              opc,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [CNT_W-1:0]  cnt_field,
    output logic [DATA_W-1:0] result,
    output logic [1:0]        cc,
    output logic              div_zero
);

    localparam int AMT_W = CNT_W + 1;

    logic [AMT_W-1:0]         amt;
    logic [DATA_W-1:0]        x_next;
    logic [DATA_W-1:0]        divisor;
    logic signed [DATA_W-1:0] quotient;

    // Three-way signed compare into the condition-code encoding
    function automatic logic [1:0] cmp3(input logic [DATA_W-1:0] l, input logic [DATA_W-1:0] r);
        if ($signed(l) < $signed(r))  return CC_LT;
        else if (l == r)              return CC_EQ;
        else                          return CC_GT;
    endfunction

    assign amt      = AMT_W'(cnt_field) + AMT_W'(1);
    assign x_next   = b + DATA_W'(1);
    assign div_zero = (opc == OPC_DIV) && (a == '0);
    assign divisor  = (a == '0) ? DATA_W'(1) : a;
    assign quotient = $signed(b) / $signed(divisor);

    // Select the operation result and condition code
    always_comb begin
        result = '0;
        cc     = CC_EQ;
        case (opc)
            OPC_ADD: result = b + a;
            OPC_SUB: result = b - a;
            OPC_MUL: result = b * a;
            OPC_DIV: result = quotient;
            OPC_CMP: cc     = cmp3(a, b);
            OPC_SHL: result = (a << amt) | (a >> (DATA_W - int'(amt)));
            OPC_SHR: result = a >> amt;
            OPC_MOV: result = a;
            OPC_CLR: result = '0;
            OPC_TIX: begin
                result = x_next;
                cc     = cmp3(x_next, a);
            end
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/rrx_unit.sv
// Register-to-register execution unit (top). Presents the register write and
// condition-code strobes during the start cycle, so the register file commits
// them on the edge where done rises. done and illegal are registered.
// Assumes combinational register-file read data on both ports.
module rrx_unit
    import rrx_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        op_byte,
    input  logic [7:0]        reg_byte,
    output logic [3:0]        rd_addr_a,
    input  logic [DATA_W-1:0] rd_data_a,
    output logic [3:0]        rd_addr_b,
    input  logic [DATA_W-1:0] rd_data_b,
    output logic              wr_en,
    output logic [3:0]        wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              cc_we,
    output logic [1:0]        cc_val,
    output logic              done,
    output logic              illegal
);

    opc_e              opc;
    logic [CODE_W-1:0] r2_field;
    logic              has_write;
    logic              has_cc;
    logic              legal;
    logic              div_zero;
    logic              ok_to_commit;
    logic              done_q;
    logic              illegal_q;

    rrx_decode u_dec (
        .op_byte   (op_byte),
        .reg_byte  (reg_byte),
        .opc       (opc),
        .r2_field  (r2_field),
        .rd_addr_a (rd_addr_a),
        .rd_addr_b (rd_addr_b),
        .wr_addr   (wr_addr),
        .has_write (has_write),
        .has_cc    (has_cc),
        .legal     (legal)
    );

    rrx_alu #(.DATA_W(DATA_W), .CNT_W(CODE_W)) u_alu (
        .opc       (opc),
        .a         (rd_data_a),
        .b         (rd_data_b),
        .cnt_field (r2_field),
        .result    (wr_data),
        .cc        (cc_val),
        .div_zero  (div_zero)
    );

    // An operation commits only when started, legal and not dividing by zero
    assign ok_to_commit = start && legal && !div_zero;
    assign wr_en        = ok_to_commit && has_write;
    assign cc_we        = ok_to_commit && has_cc;

    // Completion and fault flags, one cycle after start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            done_q    <= start;
            illegal_q <= start && (!legal || div_zero);
        end
    end

    assign done    = done_q;
    assign illegal = illegal_q;

    assert_done_follows_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    assert_no_spurious_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |-> (!wr_en && !cc_we));
    assert_illegal_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done);
    assert_dual_update_is_x_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cc_we) |-> (wr_addr == RC_X));
    assert_cc_encoding_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cc_we |-> (cc_val != 2'd3));

endmodule

// File: tb/tb_rrx_unit.sv
`timescale 1ns/1ps
module tb_rrx_unit;

    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [7:0]   op_byte = 8'h00;
    logic [7:0]   reg_byte = 8'h00;
    logic [3:0]   rd_addr_a, rd_addr_b, wr_addr;
    logic [W-1:0] rd_data_a, rd_data_b, wr_data;
    logic         wr_en, cc_we, done, illegal;
    logic [1:0]   cc_val;

    logic [W-1:0] rf [16];
    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    assign rd_data_a = rf[rd_addr_a];
    assign rd_data_b = rf[rd_addr_b];

    rrx_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_byte(op_byte), .reg_byte(reg_byte),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a), .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cc_we(cc_we), .cc_val(cc_val),
        .done(done), .illegal(illegal)
    );

    typedef struct packed {
        logic [3:0]   req;
        logic [7:0]   op;
        logic [7:0]   rb;
        logic [W-1:0] v1;
        logic [W-1:0] v2;
        logic [W-1:0] vx;
        logic         ewe;
        logic [3:0]   ewa;
        logic [W-1:0] ewd;
        logic         ecwe;
        logic [1:0]   ecc;
        logic         eill;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{4'd3, 8'h90, 8'h04, 24'h000005, 24'h000003, 24'h0, 1'b1, 4'h4, 24'h000008, 1'b0, 2'd0, 1'b0}, // R3 add
        '{4'd3, 8'h90, 8'h04, 24'hFFFFFF, 24'h000002, 24'h0, 1'b1, 4'h4, 24'h000001, 1'b0, 2'd0, 1'b0}, // R3 wrap
        '{4'd3, 8'h94, 8'h04, 24'h000005, 24'h000003, 24'h0, 1'b1, 4'h4, 24'hFFFFFE, 1'b0, 2'd0, 1'b0}, // R3 sub
        '{4'd4, 8'h98, 8'h35, 24'h001000, 24'h001001, 24'h0, 1'b1, 4'h5, 24'h001000, 1'b0, 2'd0, 1'b0}, // R4 mul low bits
        '{4'd4, 8'h9C, 8'h04, 24'h000003, 24'hFFFFF9, 24'h0, 1'b1, 4'h4, 24'hFFFFFE, 1'b0, 2'd0, 1'b0}, // R4 -7/3
        '{4'd4, 8'h9C, 8'h04, 24'hFFFFFF, 24'h800000, 24'h0, 1'b1, 4'h4, 24'h800000, 1'b0, 2'd0, 1'b0}, // R4 min/-1
        '{4'd5, 8'h9C, 8'h04, 24'h000000, 24'h000007, 24'h0, 1'b0, 4'h0, 24'h000000, 1'b0, 2'd0, 1'b1}, // R5 div zero
        '{4'd6, 8'hAC, 8'h25, 24'hABCDEF, 24'h111111, 24'h0, 1'b1, 4'h5, 24'hABCDEF, 1'b0, 2'd0, 1'b0}, // R6 move
        '{4'd6, 8'hB4, 8'h3F, 24'h123456, 24'hFFFFFF, 24'h0, 1'b1, 4'h3, 24'h000000, 1'b0, 2'd0, 1'b0}, // R6 clear, r2 ignored
        '{4'd7, 8'hA4, 8'h03, 24'h812345, 24'h000000, 24'h0, 1'b1, 4'h0, 24'h123458, 1'b0, 2'd0, 1'b0}, // R7 rotate 4
        '{4'd7, 8'hA8, 8'h0F, 24'h812345, 24'h000000, 24'h0, 1'b1, 4'h0, 24'h000081, 1'b0, 2'd0, 1'b0}, // R7 shr 16
        '{4'd7, 8'hA4, 8'h0F, 24'h0000FF, 24'h000000, 24'h0, 1'b1, 4'h0, 24'hFF0000, 1'b0, 2'd0, 1'b0}, // R7 rotate 16
        '{4'd8, 8'hA0, 8'h04, 24'hFFFFFF, 24'h000001, 24'h0, 1'b0, 4'h0, 24'h000000, 1'b1, 2'd0, 1'b0}, // R8 less signed
        '{4'd8, 8'hA0, 8'h04, 24'h00005A, 24'h00005A, 24'h0, 1'b0, 4'h0, 24'h000000, 1'b1, 2'd1, 1'b0}, // R8 equal
        '{4'd8, 8'hA0, 8'h04, 24'h7FFFFF, 24'h800000, 24'h0, 1'b0, 4'h0, 24'h000000, 1'b1, 2'd2, 1'b0}, // R8 greater
        '{4'd9, 8'hB8, 8'h50, 24'h000005, 24'h000000, 24'h4, 1'b1, 4'h1, 24'h000005, 1'b1, 2'd1, 1'b0}, // R9 equal
        '{4'd9, 8'hB8, 8'h50, 24'h000003, 24'h000000, 24'hFFFFFF, 1'b1, 4'h1, 24'h000000, 1'b1, 2'd0, 1'b0}, // R9 wrap
        '{4'd9, 8'hB8, 8'h50, 24'h000003, 24'h000000, 24'h5, 1'b1, 4'h1, 24'h000006, 1'b1, 2'd2, 1'b0}, // R9 greater
        '{4'd1, 8'hB0, 8'h00, 24'h000001, 24'h000002, 24'h0, 1'b0, 4'h0, 24'h000000, 1'b0, 2'd0, 1'b1}, // R1 unknown opcode
        '{4'd2, 8'h90, 8'h70, 24'h000001, 24'h000002, 24'h0, 1'b0, 4'h0, 24'h000000, 1'b0, 2'd0, 1'b1}, // R2 bad r1
        '{4'd2, 8'hA0, 8'h0A, 24'h000001, 24'h000002, 24'h0, 1'b0, 4'h0, 24'h000000, 1'b0, 2'd0, 1'b1}, // R2 bad r2
        '{4'd1, 8'h93, 8'h04, 24'h000001, 24'h000002, 24'h0, 1'b1, 4'h4, 24'h000003, 1'b0, 2'd0, 1'b0}, // R1 low bits ignored
        '{4'd2, 8'h90, 8'h08, 24'h000001, 24'h000010, 24'h0, 1'b1, 4'h8, 24'h000011, 1'b0, 2'd0, 1'b0}, // R2 code 8 legal
        '{4'd6, 8'hAC, 8'h09, 24'h000002, 24'h000000, 24'h0, 1'b1, 4'h9, 24'h000002, 1'b0, 2'd0, 1'b0}, // R6 move to code 9
        '{4'd1, 8'h00, 8'h04, 24'h000001, 24'h000002, 24'h0, 1'b0, 4'h0, 24'h000000, 1'b0, 2'd0, 1'b1}, // R1 opcode 0x00
        '{4'd2, 8'hB8, 8'h70, 24'h000001, 24'h000000, 24'h1, 1'b0, 4'h0, 24'h000000, 1'b0, 2'd0, 1'b1}, // R2 index bad r1
        '{4'd2, 8'hB8, 8'h5F, 24'h000005, 24'h000009, 24'h1, 1'b1, 4'h1, 24'h000002, 1'b1, 2'd0, 1'b0}  // R2 index r2 ignored
    };

    task automatic chk(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        for (int i = 0; i < 16; i++) rf[i] = '0;
        rf[1] = v.vx;
        rf[v.rb[7:4]] = v.v1;
        rf[v.rb[3:0]] = v.v2;
        op_byte  = v.op;
        reg_byte = v.rb;
        start    = 1'b1;
        #1;
        chk(wr_en == v.ewe, int'(v.req), "wr_en", 32'(wr_en), 32'(v.ewe));
        if (v.ewe) begin
            chk(wr_addr == v.ewa, int'(v.req), "wr_addr", 32'(wr_addr), 32'(v.ewa));
            chk(wr_data == v.ewd, int'(v.req), "wr_data", 32'(wr_data), 32'(v.ewd));
        end
        chk(cc_we == v.ecwe, int'(v.req), "cc_we", 32'(cc_we), 32'(v.ecwe));
        if (v.ecwe) chk(cc_val == v.ecc, int'(v.req), "cc_val", 32'(cc_val), 32'(v.ecc));
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, 10, "done", 32'(done), 32'd1);
        chk(illegal == v.eill, int'(v.req), "illegal", 32'(illegal), 32'(v.eill));
    endtask

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = '0;
        repeat (3) @(negedge clk);
        // R11: reset state, start held high during reset
        start = 1'b1;
        op_byte = 8'h9C; reg_byte = 8'h04;
        @(negedge clk);
        chk(done == 1'b0, 11, "done in reset", 32'(done), 32'd0);
        chk(illegal == 1'b0, 11, "illegal in reset", 32'(illegal), 32'd0);
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, 11, "done after reset", 32'(done), 32'd0);
        chk(illegal == 1'b0, 11, "illegal after reset", 32'(illegal), 32'd0);

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R10: no strobes without start, and no done after an idle cycle
        @(negedge clk);
        op_byte = 8'h90; reg_byte = 8'h04; rf[0] = 24'h1; rf[4] = 24'h2;
        #1;
        chk(wr_en == 1'b0, 10, "idle wr_en", 32'(wr_en), 32'd0);
        chk(cc_we == 1'b0, 10, "idle cc_we", 32'(cc_we), 32'd0);
        @(negedge clk);
        chk(done == 1'b0, 10, "idle done", 32'(done), 32'd0);

        // R10: back-to-back starts give done in both following cycles, then low
        start = 1'b1;
        @(negedge clk);
        chk(done == 1'b1, 10, "b2b done 1", 32'(done), 32'd1);
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, 10, "b2b done 2", 32'(done), 32'd1);
        @(negedge clk);
        chk(done == 1'b0, 10, "b2b done end", 32'(done), 32'd0);

        // R11: reset taken in a start cycle suppresses done
        start = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        start = 1'b0; rst_n = 1'b1;
        chk(done == 1'b0, 11, "done after reset in start", 32'(done), 32'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL R10 watchdog: actual %h expected %h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule